// File: doc/BRIEF.md
# PLL Settings Register Block with Unlock-Sequence Commit

This block sits between a simple register bus and an external PLL. Software writes the PLL enable, connect, multiplier and divider values into a set of pending registers. Those values do not reach the PLL control outputs until software writes a two-value unlock sequence to a feed register. The sequence is 0xAA followed immediately by 0x55 on the feed register. The unlock makes an accidental reprogramming of the core clock source very unlikely.

A read-only status word reports the multiplier, divider, enable and connect that are currently applied to the PLL. It also reports a lock flag, which is taken from the PLL's lock line and qualified by the applied enable. A connect request is honoured only together with an enable. The applied connect bit therefore selects the PLL as the core clock source, and when it is clear the oscillator clock is the source.

Writes are single-cycle strobes. Reads are combinational on the address lines.

Top module: `pll_feed_regs`

## Requirements
- R1: After reset, all pending and applied fields are zero, the feed register reads 0, and no unlock sequence is in progress.
- R2: Register addresses are 0 for control, 1 for configuration, 2 for status and 3 for feed. In the control register, bit 0 is the pending enable and bit 1 is the pending connect. Control reads return these pending bits, and all other bits read zero.
- R3: The configuration register holds the multiplier in bits [14:0] and the divider in bits [23:16]. Reads return the pending values, and bits 15 and [31:24] read zero.
- R4: Writes to the control or configuration registers leave the PLL outputs and the status register unchanged until a commit.
- R5: A feed write of 0x55 that directly follows a feed write of 0xAA copies all pending fields to the applied fields. The PLL outputs change on the clock edge that captures the 0x55 write. Writes to other registers do not count as feed writes.
- R6: When an unlock sequence is armed, any feed value other than 0x55 (0xAA included) cancels it without a commit. A 0x55 written with no armed sequence does nothing.
- R7: Control or configuration writes made between the 0xAA and the 0x55 update the pending values and do not cancel the sequence. The commit then uses the newest values.
- R8: The applied connect is 1 only if the pending enable was also 1 at commit. The connect output is never high while the enable output is low.
- R9: A read of the feed register returns, in bits [7:0], the last value written to it.
- R10: The status register holds the applied multiplier in bits [14:0] and the applied divider in bits [23:16]. Bit 24 is the applied enable. Bit 25 is the applied connect, where 1 means the PLL drives the core clock and 0 means the oscillator does. Bit 26 is the lock flag. Writes to the status register have no effect.
- R11: The lock flag equals the PLL lock input AND the applied enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | 2 | Register select for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pll_lock_in | input | 1 | Lock indication from the PLL |
| pll_en_o | output | 1 | Applied enable to the PLL |
| pll_conn_o | output | 1 | Applied connect: 1 selects the PLL as core clock source |
| pll_mult_o | output | 15 | Applied multiplier |
| pll_div_o | output | 8 | Applied divider |

## Verification
The assertions check the following on every cycle:
- The connect output is never high without the enable output.
- The PLL outputs stay unchanged except across a 0x55 feed write.
- The status fields mirror the applied outputs.
- The lock bit is the qualified lock input.
- A feed read returns the value written just before it.

Other behaviour depends on write order, and only the bench's scenarios show it. These scenarios include:
- a clean commit;
- a sequence cancelled by a stray value or by a repeated 0xAA;
- a lone 0x55;
- a configuration change slipped in between the two feed writes;
- a connect request without enable.

// File: rtl/pll_feed_pkg.sv
package pll_feed_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_FEED = 2'd3;

  localparam logic [7:0] FEED_KEY_A = 8'hAA;
  localparam logic [7:0] FEED_KEY_B = 8'h55;

  typedef enum logic {FEED_IDLE, FEED_ARMED} feed_state_e;
endpackage

// File: rtl/pll_feed_seq.sv
module pll_feed_seq
  import pll_feed_pkg::*;
#(
  parameter int FEED_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              feed_wr,
  input  logic [FEED_W-1:0] feed_data,
  output logic              commit,
  output logic [FEED_W-1:0] feed_q
);
  feed_state_e state_q, state_d;

  // next state: only feed writes move the sequencer
  always_comb begin
    state_d = state_q;
    commit  = 1'b0;
    if (feed_wr) begin
      case (state_q)
        FEED_IDLE: begin
          if (feed_data == FEED_W'(FEED_KEY_A)) state_d = FEED_ARMED;
        end
        FEED_ARMED: begin
          state_d = FEED_IDLE;
          commit  = (feed_data == FEED_W'(FEED_KEY_B));
        end
        default: state_d = FEED_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FEED_IDLE;
      feed_q  <= '0;
    end else begin
      state_q <= state_d;
      if (feed_wr) feed_q <= feed_data;
    end
  end
endmodule

// File: rtl/pll_feed_shadow.sv
module pll_feed_shadow #(
  parameter int MULT_W = 15,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              cfg_wr,
  input  logic              wr_en,
  input  logic              wr_conn,
  input  logic [MULT_W-1:0] wr_mult,
  input  logic [DIV_W-1:0]  wr_div,
  input  logic              commit,
  output logic              pend_en,
  output logic              pend_conn,
  output logic [MULT_W-1:0] pend_mult,
  output logic [DIV_W-1:0]  pend_div,
  output logic              act_en,
  output logic              act_conn,
  output logic [MULT_W-1:0] act_mult,
  output logic [DIV_W-1:0]  act_div
);
  logic              pend_en_d, pend_conn_d;
  logic [MULT_W-1:0] pend_mult_d;
  logic [DIV_W-1:0]  pend_div_d;
  logic              act_en_d, act_conn_d;
  logic [MULT_W-1:0] act_mult_d;
  logic [DIV_W-1:0]  act_div_d;

  always_comb begin
    pend_en_d   = pend_en;
    pend_conn_d = pend_conn;
    pend_mult_d = pend_mult;
    pend_div_d  = pend_div;
    if (ctrl_wr) begin
      pend_en_d   = wr_en;
      pend_conn_d = wr_conn;
    end
    if (cfg_wr) begin
      pend_mult_d = wr_mult;
      pend_div_d  = wr_div;
    end
  end

  // applied copy: connect is granted only together with enable
  always_comb begin
    act_en_d   = act_en;
    act_conn_d = act_conn;
    act_mult_d = act_mult;
    act_div_d  = act_div;
    if (commit) begin
      act_en_d   = pend_en;
      act_conn_d = pend_conn & pend_en;
      act_mult_d = pend_mult;
      act_div_d  = pend_div;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_en   <= 1'b0;
      pend_conn <= 1'b0;
      pend_mult <= '0;
      pend_div  <= '0;
      act_en    <= 1'b0;
      act_conn  <= 1'b0;
      act_mult  <= '0;
      act_div   <= '0;
    end else begin
      pend_en   <= pend_en_d;
      pend_conn <= pend_conn_d;
      pend_mult <= pend_mult_d;
      pend_div  <= pend_div_d;
      act_en    <= act_en_d;
      act_conn  <= act_conn_d;
      act_mult  <= act_mult_d;
      act_div   <= act_div_d;
    end
  end
endmodule

// File: rtl/pll_feed_rdmux.sv
module pll_feed_rdmux
  import pll_feed_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MULT_W  = 15,
  parameter int DIV_W   = 8,
  parameter int DIV_LSB = 16,
  parameter int FEED_W  = 8
) (
  input  logic [1:0]        addr,
  input  logic              pend_en,
  input  logic              pend_conn,
  input  logic [MULT_W-1:0] pend_mult,
  input  logic [DIV_W-1:0]  pend_div,
  input  logic              act_en,
  input  logic              act_conn,
  input  logic [MULT_W-1:0] act_mult,
  input  logic [DIV_W-1:0]  act_div,
  input  logic              lock_in,
  input  logic [FEED_W-1:0] feed_q,
  output logic [DATA_W-1:0] rdata
);
  localparam int EN_BIT   = DIV_LSB + DIV_W;
  localparam int CONN_BIT = EN_BIT + 1;
  localparam int LOCK_BIT = EN_BIT + 2;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL: begin
        rdata[0] = pend_en;
        rdata[1] = pend_conn;
      end
      ADDR_CFG: begin
        rdata[MULT_W-1:0]         = pend_mult;
        rdata[DIV_LSB +: DIV_W]   = pend_div;
      end
      ADDR_STAT: begin
        rdata[MULT_W-1:0]         = act_mult;
        rdata[DIV_LSB +: DIV_W]   = act_div;
        rdata[EN_BIT]             = act_en;
        rdata[CONN_BIT]           = act_conn;
        rdata[LOCK_BIT]           = lock_in & act_en;
      end
      default: rdata[FEED_W-1:0] = feed_q;
    endcase
  end
endmodule

// File: rtl/pll_feed_regs.sv
module pll_feed_regs
  import pll_feed_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int MULT_W  = 15,
  parameter int DIV_W   = 8,
  parameter int DIV_LSB = 16,
  parameter int FEED_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pll_lock_in,
  output logic              pll_en_o,
  output logic              pll_conn_o,
  output logic [MULT_W-1:0] pll_mult_o,
  output logic [DIV_W-1:0]  pll_div_o
);
  logic              ctrl_wr, cfg_wr, feed_wr, commit;
  logic [FEED_W-1:0] feed_q;
  logic              pend_en, pend_conn;
  logic [MULT_W-1:0] pend_mult;
  logic [DIV_W-1:0]  pend_div;
  logic              unused_wdata;

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign cfg_wr  = reg_wr && (reg_addr == ADDR_CFG);
  assign feed_wr = reg_wr && (reg_addr == ADDR_FEED);
  assign unused_wdata = ^reg_wdata;

  pll_feed_seq #(.FEED_W(FEED_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .feed_wr   (feed_wr),
    .feed_data (reg_wdata[FEED_W-1:0]),
    .commit    (commit),
    .feed_q    (feed_q)
  );

  pll_feed_shadow #(.MULT_W(MULT_W), .DIV_W(DIV_W)) shadow_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .cfg_wr    (cfg_wr),
    .wr_en     (reg_wdata[0]),
    .wr_conn   (reg_wdata[1]),
    .wr_mult   (reg_wdata[MULT_W-1:0]),
    .wr_div    (reg_wdata[DIV_LSB +: DIV_W]),
    .commit    (commit),
    .pend_en   (pend_en),
    .pend_conn (pend_conn),
    .pend_mult (pend_mult),
    .pend_div  (pend_div),
    .act_en    (pll_en_o),
    .act_conn  (pll_conn_o),
    .act_mult  (pll_mult_o),
    .act_div   (pll_div_o)
  );

  pll_feed_rdmux #(
    .DATA_W(DATA_W), .MULT_W(MULT_W), .DIV_W(DIV_W),
    .DIV_LSB(DIV_LSB), .FEED_W(FEED_W)
  ) rdmux_i (
    .addr      (reg_addr),
    .pend_en   (pend_en),
    .pend_conn (pend_conn),
    .pend_mult (pend_mult),
    .pend_div  (pend_div),
    .act_en    (pll_en_o),
    .act_conn  (pll_conn_o),
    .act_mult  (pll_mult_o),
    .act_div   (pll_div_o),
    .lock_in   (pll_lock_in),
    .feed_q    (feed_q),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/pll_feed_chk.sv
module pll_feed_chk #(
  parameter int DATA_W  = 32,
  parameter int MULT_W  = 15,
  parameter int DIV_W   = 8,
  parameter int DIV_LSB = 16,
  parameter int FEED_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              pll_lock_in,
  input logic              pll_en_o,
  input logic              pll_conn_o,
  input logic [MULT_W-1:0] pll_mult_o,
  input logic [DIV_W-1:0]  pll_div_o
);
  localparam int EN_BIT = DIV_LSB + DIV_W;

  logic feed_any, feed_b;
  assign feed_any = reg_wr && (reg_addr == 2'd3);
  assign feed_b   = feed_any && (reg_wdata[7:0] == 8'h55);

  // R8
  conn_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en_o |-> !pll_conn_o);

  // R4
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !feed_b |=> $stable({pll_en_o, pll_conn_o, pll_mult_o, pll_div_o}));

  // R10
  status_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (reg_rdata[MULT_W-1:0] == pll_mult_o &&
                            reg_rdata[DIV_LSB +: DIV_W] == pll_div_o &&
                            reg_rdata[EN_BIT] == pll_en_o &&
                            reg_rdata[EN_BIT+1] == pll_conn_o));

  // R11
  lock_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (reg_rdata[EN_BIT+2] == (pll_lock_in && pll_en_o)));

  // R9
  feed_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed_any |=> (reg_addr != 2'd3 ||
                  reg_rdata[FEED_W-1:0] == $past(reg_wdata[FEED_W-1:0])));

  // R3
  cfg_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata[DATA_W-1:DIV_LSB+DIV_W] == '0 &&
                            reg_rdata[MULT_W] == 1'b0));
endmodule

bind pll_feed_regs pll_feed_chk #(
  .DATA_W(DATA_W), .MULT_W(MULT_W), .DIV_W(DIV_W),
  .DIV_LSB(DIV_LSB), .FEED_W(FEED_W)
) chk_i (.*);

// File: tb/pll_feed_regs_tb_top.sv
`timescale 1ns/1ps
module pll_feed_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        pll_lock_in;
  logic        pll_en_o, pll_conn_o;
  logic [14:0] pll_mult_o;
  logic [7:0]  pll_div_o;

  always #2 clk = ~clk;

  pll_feed_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pll_lock_in(pll_lock_in),
    .pll_en_o(pll_en_o), .pll_conn_o(pll_conn_o),
    .pll_mult_o(pll_mult_o), .pll_div_o(pll_div_o)
  );

  // bench model of the registers
  logic        m_pen, m_pconn, m_aen, m_aconn, m_armed;
  logic [14:0] m_pmult, m_amult;
  logic [7:0]  m_pdiv, m_adiv, m_feed;

  // scoreboard queues
  logic [31:0] q_rd[$];
  logic [24:0] q_pins[$];
  int          q_req[$];
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 0;

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      2'd0: r = {30'd0, m_pconn, m_pen};
      2'd1: r = {8'd0, m_pdiv, 1'b0, m_pmult};
      2'd2: r = {5'd0, pll_lock_in & m_aen, m_aconn, m_aen, m_adiv, 1'b0, m_amult};
      default: r = {24'd0, m_feed};
    endcase
    return r;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    case (a)
      2'd0: begin m_pen = d[0]; m_pconn = d[1]; end
      2'd1: begin m_pmult = d[14:0]; m_pdiv = d[23:16]; end
      2'd3: begin
        m_feed = d[7:0];
        if (m_armed) begin
          m_armed = 1'b0;
          if (d[7:0] == 8'h55) begin
            m_aen = m_pen; m_aconn = m_pconn & m_pen;
            m_amult = m_pmult; m_adiv = m_pdiv;
          end
        end else m_armed = (d[7:0] == 8'hAA);
      end
      default: ;
    endcase
  endtask

  task automatic chk(input logic [1:0] a, input int req);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a;
    q_rd.push_back(exp_rd(a));
    q_pins.push_back({m_aen, m_aconn, m_adiv, m_amult});
    q_req.push_back(req);
    wait (q_req.size() == 0);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q_req.size() > 0) begin
        logic [31:0] er; logic [24:0] ep; int rq;
        er = q_rd.pop_front(); ep = q_pins.pop_front(); rq = q_req.pop_front();
        n_vec++;
        if (reg_rdata !== er || {pll_en_o, pll_conn_o, pll_div_o, pll_mult_o} !== ep) begin
          n_bad++;
          $display("FAIL R%0d addr=%0d rdata=%h exp=%h pins=%h exp=%h", rq, reg_addr,
                   reg_rdata, er, {pll_en_o, pll_conn_o, pll_div_o, pll_mult_o}, ep);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    {m_pen, m_pconn, m_aen, m_aconn, m_armed} = '0;
    m_pmult = '0; m_amult = '0; m_pdiv = '0; m_adiv = '0; m_feed = '0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0; pll_lock_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state of every register
    for (int i = 0; i < 4; i++) chk(2'(i), 1);
    // R2 R3 R4 pending writes, outputs untouched
    wr(2'd0, 32'hFFFF_FFFF); chk(2'd0, 2);
    wr(2'd1, 32'hFFFF_FFFF); chk(2'd1, 3);
    wr(2'd1, 32'h0005_1234); chk(2'd2, 4);
    // R5 clean commit, R10 R11 status with lock high
    pll_lock_in = 1'b1;
    wr(2'd3, 32'hAA); wr(2'd3, 32'h55); chk(2'd2, 5);
    chk(2'd2, 11);
    // R9 feed readback
    chk(2'd3, 9);
    // R8 connect without enable
    wr(2'd0, 32'h2); wr(2'd3, 32'hAA); wr(2'd3, 32'h55); chk(2'd2, 8);
    chk(2'd2, 11);
    // R6 stray value aborts
    wr(2'd0, 32'h3); wr(2'd1, 32'h0009_0042);
    wr(2'd3, 32'hAA); wr(2'd3, 32'h12); wr(2'd3, 32'h55); chk(2'd2, 6);
    chk(2'd3, 9);
    // R6 repeated AA aborts
    wr(2'd3, 32'hAA); wr(2'd3, 32'hAA); wr(2'd3, 32'h55); chk(2'd2, 6);
    // R6 lone 55 does nothing
    wr(2'd3, 32'h55); chk(2'd2, 6);
    // R7 config write inside sequence still commits with new value
    wr(2'd3, 32'hAA); wr(2'd1, 32'h0011_7ABC); wr(2'd0, 32'h3); wr(2'd3, 32'h55);
    chk(2'd2, 7);
    // R10 status write ignored
    wr(2'd2, 32'hFFFF_FFFF); chk(2'd2, 10);
    // R11 lock input drop
    pll_lock_in = 1'b0; chk(2'd2, 11);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule